// File: doc/BRIEF.md
# NAND Page Flash Target

A synthesizable, scaled-down model of a page-organised NAND flash device that a host sequencer can drive cycle by cycle. Each bus cycle is one clock with a write or read strobe. On a write strobe, the command-latch and address-latch qualifiers choose between three meanings for the input byte: a command opcode, an address byte or a data byte. The block holds a small erasable array, a single page register and a count of partial programs for each page. It reports ready/busy on a dedicated pin and also returns a status byte.

Supported operations: page read, column jump within the loaded page, page program, column jump while loading program data, block erase, status read, identification read and reset. Busy periods are counted in clocks. Programming can only clear bits. Erasing sets a whole block back to ones. Write protection makes both program and erase fail without altering the array.

Top module: `nand_target`

## Requirements
- R1: After reset the ready output is 1 and the whole array reads FFh.
- R2: Command 00h, five address bytes (column low, column high, then three row bytes with the page index in the low row bits and the block index above it), then 30h: the device is busy for T_READ clocks, then loads the page register. Each read strobe returns the byte at the column and advances the column.
- R3: Command 80h presets the page register to all FFh. Data strobes write bytes at the column and advance it. When the program completes, the stored page becomes the old contents AND the register.
- R4: Command 85h followed by two column bytes moves the data-input column inside a pending program. Nothing is stored until 10h.
- R5: Command 05h, two column bytes, then E0h moves the read column inside the already loaded page register.
- R6: 60h, three row bytes, then D0h erases the whole addressed block to FFh. The page bits of the row are ignored, and other blocks are left unchanged.
- R7: While busy, every command except FFh and 70h is ignored, as are address and data cycles.
- R8: FFh while busy ends the operation at once: ready returns the next cycle and the array is unchanged.
- R9: After 70h each read strobe returns the status byte, without the command being issued again. The byte is laid out as: bit 0 = last program/erase failed, bits 5 and 6 = ready, bit 7 = write-protect input high (not protected), other bits 0.
- R10: A page accepts at most four programs between erases. A fifth sets the fail bit and leaves the page unchanged, and an erase clears the count.
- R11: With the write-protect input low, program and erase fail (status bit 0 = 1) without altering the array, and status bit 7 reads 0.
- R12: 90h with one address byte returns five identification bytes on successive read strobes: A7h, 5Ch, then log2 of page bytes, pages per block, and blocks.
- R13: Program and erase keep ready low for exactly T_PROG and T_ERASE clocks respectively, counted from the confirm cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_latch | input | 1 | Write cycle carries a command |
| addr_latch | input | 1 | Write cycle carries an address byte |
| wr_strobe | input | 1 | One-clock write cycle strobe |
| rd_strobe | input | 1 | One-clock read cycle strobe |
| wp_n | input | 1 | Write protect, low = protected |
| bus_in | input | 8 | Command, address or data byte |
| bus_out | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | 1 = idle, 0 = busy |

## Verification
The bench goes after the bit-clearing rule. A design that overwrote cells instead of ANDing them would return F0h where 50h is due. A page register left holding stale data instead of being preset would corrupt unwritten columns. The bench also checks cycles issued during a busy period. A design that accepted 80h or data there would change the page being programmed, and an abort that still completed would leave zeros in a page that must read FFh. The bench checks the fifth partial program, erase with non-zero page bits, and write-protected program and erase. In each case a design that miscounted, masked the wrong row bits or ignored the protect input would alter the array or report a pass.

// File: rtl/nand_target.sv
module nand_target #(
  parameter int BLOCKS      = 4,
  parameter int PAGES       = 4,
  parameter int PAGE_BYTES  = 16,
  parameter int T_READ      = 5,
  parameter int T_PROG      = 44,
  parameter int T_ERASE     = 100,
  parameter int MAX_PARTIAL = 4,
  parameter logic [7:0] ID0 = 8'hA7,
  parameter logic [7:0] ID1 = 8'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       wr_strobe,
  input  logic       rd_strobe,
  input  logic       wp_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       ready
);
  localparam int CW  = $clog2(PAGE_BYTES);
  localparam int PW  = $clog2(PAGES);
  localparam int BW  = $clog2(BLOCKS);
  localparam int RW  = PW + BW;
  localparam int NPG = BLOCKS * PAGES;
  localparam int NB  = NPG * PAGE_BYTES;
  localparam int TW  = $clog2(T_ERASE + 1);

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_RREAD, OP_PROG, OP_ERASE, OP_ID} op_t;
  typedef enum logic [1:0] {M_STATUS, M_PAGE, M_ID} mode_t;

  logic [7:0]    mem  [NB];
  logic [7:0]    preg [PAGE_BYTES];
  logic [2:0]    pcnt [NPG];
  op_t           op, pend;
  mode_t         mode;
  logic          busy, fail, wp_hold;
  logic [TW-1:0] tmr;
  logic [2:0]    acnt, aidx;
  logic [7:0]    col_lo;
  logic [CW:0]   col_ptr;
  logic [23:0]   row;
  logic [2:0]    id_idx;
  logic [7:0]    status, id_byte;

  wire cmd_w   = wr_strobe & cmd_latch & ~addr_latch;
  wire adr_w   = wr_strobe & addr_latch & ~cmd_latch;
  wire dat_w   = wr_strobe & ~cmd_latch & ~addr_latch;
  wire abort_w = cmd_w & (bus_in == 8'hFF);
  wire in_page = col_ptr < (CW+1)'(PAGE_BYTES);
  wire done    = busy & (tmr == '0);
  wire [RW-1:0] pg  = row[RW-1:0];
  wire [BW-1:0] blk = row[RW-1:PW];

  assign ready  = ~busy;
  assign status = {wp_n, ~busy, ~busy, 3'b000, 1'b0, fail};
  assign aidx   = acnt + ((op == OP_ERASE) ? 3'd2 : 3'd0);

  always_comb
    case (id_idx)
      3'd0: id_byte = ID0;
      3'd1: id_byte = ID1;
      3'd2: id_byte = 8'(CW);
      3'd3: id_byte = 8'(PW);
      3'd4: id_byte = 8'(BW);
      default: id_byte = 8'h00;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) preg[i] <= 8'hFF;
      for (int i = 0; i < NPG; i++) pcnt[i] <= '0;
      op <= OP_NONE; pend <= OP_NONE; mode <= M_STATUS;
      busy <= 1'b0; fail <= 1'b0; wp_hold <= 1'b1; tmr <= '0;
      acnt <= '0; col_lo <= '0; col_ptr <= '0; row <= '0;
      id_idx <= '0; bus_out <= '0;
    end else begin
      if (busy) begin
        if (done) begin
          busy <= 1'b0;
          case (pend)
            OP_READ: begin
              for (int i = 0; i < PAGE_BYTES; i++) preg[i] <= mem[{pg, CW'(i)}];
              mode <= M_PAGE;
            end
            OP_PROG:
              if (!wp_hold || pcnt[pg] >= 3'(MAX_PARTIAL)) fail <= 1'b1;
              else begin
                for (int i = 0; i < PAGE_BYTES; i++)
                  mem[{pg, CW'(i)}] <= mem[{pg, CW'(i)}] & preg[i];
                pcnt[pg] <= pcnt[pg] + 3'd1;
                fail <= 1'b0;
              end
            OP_ERASE:
              if (!wp_hold) fail <= 1'b1;
              else begin
                for (int p = 0; p < PAGES; p++) begin
                  pcnt[{blk, PW'(p)}] <= '0;
                  for (int i = 0; i < PAGE_BYTES; i++) mem[{blk, PW'(p), CW'(i)}] <= 8'hFF;
                end
                fail <= 1'b0;
              end
            default: ;
          endcase
        end else tmr <= tmr - 1'b1;
      end

      if (cmd_w) begin
        if (bus_in == 8'hFF) begin
          busy <= 1'b0; op <= OP_NONE; fail <= 1'b0; mode <= M_STATUS;
        end else if (bus_in == 8'h70) begin
          mode <= M_STATUS;
        end else if (!busy) begin
          case (bus_in)
            8'h00: begin op <= OP_READ;  acnt <= '0; end
            8'h05: begin op <= OP_RREAD; acnt <= '0; end
            8'h60: begin op <= OP_ERASE; acnt <= '0; end
            8'h90: begin op <= OP_ID;    acnt <= '0; end
            8'h80: begin
              op <= OP_PROG; acnt <= '0;
              for (int i = 0; i < PAGE_BYTES; i++) preg[i] <= 8'hFF;
            end
            8'h85: if (op == OP_PROG) acnt <= '0;
            8'h30: if (op == OP_READ) begin
              busy <= 1'b1; tmr <= TW'(T_READ - 1); pend <= OP_READ; op <= OP_NONE;
            end
            8'hE0: if (op == OP_RREAD) begin mode <= M_PAGE; op <= OP_NONE; end
            8'h10: if (op == OP_PROG) begin
              busy <= 1'b1; tmr <= TW'(T_PROG - 1); pend <= OP_PROG;
              wp_hold <= wp_n; op <= OP_NONE;
            end
            8'hD0: if (op == OP_ERASE) begin
              busy <= 1'b1; tmr <= TW'(T_ERASE - 1); pend <= OP_ERASE;
              wp_hold <= wp_n; op <= OP_NONE;
            end
            default: op <= OP_NONE;
          endcase
        end
      end

      if (adr_w && !busy) begin
        acnt <= acnt + 3'd1;
        case (aidx)
          3'd0: col_lo <= bus_in;
          3'd1: col_ptr <= (CW+1)'({bus_in, col_lo});
          3'd2: row[7:0]   <= bus_in;
          3'd3: row[15:8]  <= bus_in;
          3'd4: row[23:16] <= bus_in;
          default: ;
        endcase
        if (op == OP_ID) begin mode <= M_ID; id_idx <= '0; end
      end

      if (dat_w && !busy && op == OP_PROG && in_page) begin
        preg[col_ptr[CW-1:0]] <= bus_in;
        col_ptr <= col_ptr + 1'b1;
      end

      if (rd_strobe)
        case (mode)
          M_STATUS: bus_out <= status;
          M_PAGE: begin
            bus_out <= in_page ? preg[col_ptr[CW-1:0]] : 8'hFF;
            if (in_page) col_ptr <= col_ptr + 1'b1;
          end
          default: begin
            bus_out <= id_byte;
            if (id_idx != 3'd7) id_idx <= id_idx + 3'd1;
          end
        endcase
    end
  end

  assert_busy_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tmr != '0 && !abort_w |=> !ready);
  assert_abort_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort_w |=> ready);
  assert_wp_fails_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && pend == OP_PROG && !wp_hold && !abort_w |=> fail);
  assert_busy_no_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_w && !rd_strobe |=> $stable(col_ptr));
  assert_status_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && mode == M_STATUS && !cmd_w |=> bus_out[6:5] == {2{$past(ready)}});
  assert_partial_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt[pg] <= 3'(MAX_PARTIAL));
endmodule

// File: tb/nand_target_bench.sv
`timescale 1ns/1ps
module nand_target_bench;
  localparam int PAGES = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 1'b0, ale = 1'b0, wr = 1'b0, rd = 1'b0, wp_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ready;
  int checks = 0, fails = 0, cycles = 0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  nand_target u_nand_target (.clk(clk), .rst_n(rst_n), .cmd_latch(cle), .addr_latch(ale),
    .wr_strobe(wr), .rd_strobe(rd), .wp_n(wp_n), .bus_in(din), .bus_out(dout), .ready(ready));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    rd_q <= rd;
    cycles <= cycles + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dout !== e) begin
        fails++;
        $display("FAIL %s: read byte got %02h expected %02h", t, dout, e);
      end
    end
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: no completion, got %0d cycles expected below 100000", cycles);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] b);
    cle = 1; wr = 1; din = b; @(negedge clk); cle = 0; wr = 0;
  endtask
  task automatic adr(logic [7:0] b);
    ale = 1; wr = 1; din = b; @(negedge clk); ale = 0; wr = 0;
  endtask
  task automatic dat(logic [7:0] b);
    wr = 1; din = b; @(negedge clk); wr = 0;
  endtask
  task automatic rdx(logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd = 1; @(negedge clk); rd = 0;
  endtask
  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
  endtask
  task automatic addr5(int col, int pg, int blk);
    int r;
    r = blk * PAGES + pg;
    adr(8'(col)); adr(8'(col >> 8)); adr(8'(r)); adr(8'(r >> 8)); adr(8'(r >> 16));
  endtask
  task automatic read1(int col, int pg, int blk, logic [7:0] e, string tag);
    int n;
    cmd(8'h00); addr5(col, pg, blk); cmd(8'h30); wait_rdy(n);
    rdx(e, tag);
  endtask
  task automatic prog1(int col, int pg, int blk, logic [7:0] d);
    int n;
    cmd(8'h80); addr5(col, pg, blk); dat(d); cmd(8'h10); wait_rdy(n);
  endtask
  task automatic erase1(int row, output int n);
    cmd(8'h60); adr(8'(row)); adr(8'h00); adr(8'h00); cmd(8'hD0); wait_rdy(n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ready), 1);
    cmd(8'h70); rdx(8'hE0, "R1 R9 status after reset"); rdx(8'hE0, "R9 status re-read");

    cmd(8'h90); adr(8'h00);
    rdx(8'hA7, "R12 id0"); rdx(8'h5C, "R12 id1"); rdx(8'h04, "R12 id2");
    rdx(8'h02, "R12 id3"); rdx(8'h02, "R12 id4");

    cmd(8'h00); addr5(0, 0, 0); cmd(8'h30); wait_rdy(n);
    chk("R2 read busy clocks", n, 5);
    rdx(8'hFF, "R1 R2 erased byte 0"); rdx(8'hFF, "R1 R2 erased byte 1");

    cmd(8'h80); addr5(3, 2, 1); dat(8'h5A); dat(8'h0F);
    cmd(8'h85); adr(8'd10); adr(8'h00); dat(8'h33);
    cmd(8'h10); wait_rdy(n);
    chk("R13 program busy clocks", n, 44);
    cmd(8'h70); rdx(8'hE0, "R9 program pass");
    prog1(0, 1, 0, 8'h3C);

    cmd(8'h00); addr5(2, 2, 1); cmd(8'h30); wait_rdy(n);
    rdx(8'hFF, "R3 unwritten col2"); rdx(8'h5A, "R2 R3 col3"); rdx(8'h0F, "R2 R3 col4");
    rdx(8'hFF, "R3 preset col5");
    cmd(8'h05); adr(8'd10); adr(8'h00); cmd(8'hE0);
    rdx(8'h33, "R4 R5 col10"); rdx(8'hFF, "R5 col11");

    prog1(3, 2, 1, 8'hF0);
    read1(3, 2, 1, 8'h50, "R3 AND of two programs");
    prog1(3, 2, 1, 8'hFF); prog1(3, 2, 1, 8'hFF);
    prog1(3, 2, 1, 8'h00);
    cmd(8'h70); rdx(8'hE1, "R10 fifth program fails");
    read1(3, 2, 1, 8'h50, "R10 page unchanged");

    erase1(1 * PAGES + 3, n);
    chk("R13 erase busy clocks", n, 100);
    cmd(8'h70); rdx(8'hE0, "R6 erase pass");
    read1(3, 2, 1, 8'hFF, "R6 block erased despite page bits");
    read1(10, 2, 1, 8'hFF, "R6 block erased col10");
    read1(0, 1, 0, 8'h3C, "R6 other block kept");
    prog1(3, 2, 1, 8'h0F);
    cmd(8'h70); rdx(8'hE0, "R10 count cleared by erase");
    read1(3, 2, 1, 8'h0F, "R10 program after erase");

    cmd(8'h80); addr5(0, 0, 2); dat(8'h00); cmd(8'h10);
    cmd(8'h70); rdx(8'h80, "R9 busy status"); rdx(8'h80, "R9 busy status re-read");
    cmd(8'hFF);
    chk("R8 ready after abort", int'(ready), 1);
    read1(0, 0, 2, 8'hFF, "R8 aborted program left array");

    cmd(8'h80); addr5(0, 0, 3); dat(8'h00); cmd(8'h10);
    cmd(8'h80); dat(8'hAA); cmd(8'h00);
    wait_rdy(n);
    read1(0, 0, 3, 8'h00, "R7 cycles during busy ignored");

    wp_n = 0;
    cmd(8'h70); rdx(8'h60, "R11 protect bit");
    prog1(0, 0, 0, 8'h00);
    cmd(8'h70); rdx(8'h61, "R11 protected program fails");
    read1(0, 0, 0, 8'hFF, "R11 protected program no change");
    erase1(3 * PAGES, n);
    cmd(8'h70); rdx(8'h61, "R11 protected erase fails");
    read1(0, 0, 3, 8'h00, "R11 protected erase no change");
    wp_n = 1;

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule